// File: doc/BRIEF.md
# Answer-to-Reset Convention Detector and Character Converter

This block sits between the raw bit shifter of a smart-card serial port and the byte FIFOs. After the host releases the card reset it arms the block. The next received character is then taken as the initial convention character. Its raw line pattern selects either direct convention or inverse convention. Under inverse convention the block complements every bit and reverses the bit order. From then on the host only ever sees direct-convention bytes, and bytes the host sends go out on the line in the card's convention.

Received characters arrive as a raw vector in which bit i is the line level of the i-th data bit after the start bit, together with the raw parity level. Even parity is checked on the decoded character. On a mismatch the block can report an error and request a break towards the card, and each of the two can be enabled on its own. The host can force a convention in place of the detected one, or switch the data conversion off.

Top module: `ts_conv_unit`

## Requirements
- R1: After reset, rx_out_valid, tx_out_valid, rx_out_perr, rx_break, ts_done and ts_err are 0, and ts_inverse is 0 (direct convention).
- R2: When armed, a raw character equal to 0x3B is classified as direct convention. ts_done becomes 1, ts_inverse becomes 0, and the character is delivered as 0x3B.
- R3: When armed, a raw character equal to 0x03 (0x3F under inverse coding) is classified as inverse convention. ts_done becomes 1, ts_inverse becomes 1, and the character is delivered as 0x3F.
- R4: When armed, any other raw character sets ts_err, leaves ts_done at 0 and leaves ts_inverse unchanged.
- R5: Only the first character after a ts_arm pulse is classified. A later character, even one equal to 0x03 or 0x3B, leaves ts_inverse unchanged.
- R6: Under inverse convention, received output bit 7-i equals the complement of raw bit i.
- R7: Transmit under direct convention gives tx_out_raw = tx_data and tx_out_par = XOR of tx_data. Under inverse convention, raw bit i = NOT tx_data[7-i] and tx_out_par = NOT (XOR of tx_data).
- R8: With conv_dis = 1, received and transmitted data bits pass through unchanged. The parity bit is still handled per the active convention.
- R9: With force_en = 1, force_inv selects the convention for both directions, overriding the detected one.
- R10: A parity mismatch is present when the decoded data bits plus the decoded parity bit (raw parity complemented under inverse) hold an odd count of ones. rx_out_perr = par_chk_en AND mismatch.
- R11: rx_break = brk_en AND mismatch, independent of par_chk_en.
- R12: rx_out_valid and tx_out_valid are high exactly in the cycle after rx_valid or tx_valid respectively, and carry that character's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_arm | input | 1 | Pulse: treat the next received character as the convention character |
| force_en | input | 1 | Use force_inv instead of the detected convention |
| force_inv | input | 1 | Forced convention, 1 = inverse |
| conv_dis | input | 1 | Pass data bits through without conversion |
| par_chk_en | input | 1 | Enable parity error reporting |
| brk_en | input | 1 | Enable break request on parity error |
| rx_valid | input | 1 | Raw received character present |
| rx_raw | input | DATA_W | Raw line levels, bit 0 first on the line |
| rx_par | input | 1 | Raw parity line level |
| tx_valid | input | 1 | Host transmit byte present |
| tx_data | input | DATA_W | Host byte in direct convention |
| rx_out_valid | output | 1 | Converted received byte valid |
| rx_out_data | output | DATA_W | Received byte in direct convention |
| rx_out_perr | output | 1 | Parity error reported |
| rx_break | output | 1 | Break request towards the card |
| tx_out_valid | output | 1 | Line character valid |
| tx_out_raw | output | DATA_W | Line levels to send, bit 0 first |
| tx_out_par | output | 1 | Parity line level to send |
| ts_inverse | output | 1 | Detected convention, 1 = inverse |
| ts_done | output | 1 | A valid convention character has been seen since arming |
| ts_err | output | 1 | The armed character matched neither pattern |

## Verification
The bench builds the block with its default parameters: an 8-bit character and the two standard convention patterns. This exposes the asymmetric bit patterns 0x3B and 0x03 on the line and makes the bit reversal visible on every non-palindromic byte. At that width the parity of a complemented byte is unchanged, so a bug in parity inversion shows up directly as a wrong error or break flag. A scoreboard compares each produced character against a reference coder under direct, inverse, forced and disabled modes, including an unrecognized convention character.

// File: rtl/ts_conv_pkg.sv
package ts_conv_pkg;
    localparam int unsigned CHAR_W_DEF   = 8;
    localparam logic [7:0]  TS_DIRECT_DEF  = 8'h3B;
    localparam logic [7:0]  TS_INVERSE_DEF = 8'h3F;

    typedef enum logic {
        CONV_DIRECT  = 1'b0,
        CONV_INVERSE = 1'b1
    } conv_e;
endpackage

// File: rtl/ts_bit_xform.sv
module ts_bit_xform #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] din,
    input  logic         pin,
    input  logic         inv,
    output logic [W-1:0] dout,
    output logic         pout
);
    localparam int unsigned TOP = W - 1;

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign dout[gi] = inv ? ~din[TOP-gi] : din[gi];
    end

    assign pout = inv ? ~pin : pin;
endmodule

// File: rtl/ts_classifier.sv
module ts_classifier #(
    parameter int unsigned W          = 8,
    parameter logic [W-1:0] PAT_DIRECT  = 8'h3B,
    parameter logic [W-1:0] PAT_INVERSE = 8'h3F
) (
    input  logic [W-1:0] raw,
    output logic         hit_direct,
    output logic         hit_inverse
);
    logic [W-1:0] inv_line_pat;
    logic         unused_par;

    ts_bit_xform #(.W(W)) u_pat (
        .din  (PAT_INVERSE),
        .pin  (1'b0),
        .inv  (1'b1),
        .dout (inv_line_pat),
        .pout (unused_par)
    );

    assign hit_direct  = (raw == PAT_DIRECT);
    assign hit_inverse = (raw == inv_line_pat);

    always_comb begin
        assert (!(hit_direct && hit_inverse) || $isunknown(raw))
            else $error("p_patterns_distinct_r4 violated");
    end
endmodule

// File: rtl/ts_conv_unit.sv
module ts_conv_unit
    import ts_conv_pkg::*;
#(
    parameter int unsigned  DATA_W     = CHAR_W_DEF,
    parameter logic [DATA_W-1:0] TS_DIRECT  = TS_DIRECT_DEF,
    parameter logic [DATA_W-1:0] TS_INVERSE = TS_INVERSE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_arm,
    input  logic              force_en,
    input  logic              force_inv,
    input  logic              conv_dis,
    input  logic              par_chk_en,
    input  logic              brk_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_raw,
    input  logic              rx_par,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rx_out_valid,
    output logic [DATA_W-1:0] rx_out_data,
    output logic              rx_out_perr,
    output logic              rx_break,
    output logic              tx_out_valid,
    output logic [DATA_W-1:0] tx_out_raw,
    output logic              tx_out_par,
    output logic              ts_inverse,
    output logic              ts_done,
    output logic              ts_err
);
    typedef struct packed {
        logic              armed;
        conv_e             det;
        logic              done;
        logic              err;
        logic              rx_vld;
        logic [DATA_W-1:0] rx_dat;
        logic              rx_perr;
        logic              rx_brk;
        logic              tx_vld;
        logic [DATA_W-1:0] tx_raw;
        logic              tx_par;
    } state_t;

    state_t st_d, st_q;

    logic              hit_dir, hit_inv;
    logic              is_ts;
    conv_e             ts_conv;
    logic              inv_rx, inv_tx;
    logic [DATA_W-1:0] rx_dec;
    logic              rx_decp;
    logic [DATA_W-1:0] tx_line;
    logic              tx_linep;
    logic              mismatch;

    ts_classifier #(
        .W           (DATA_W),
        .PAT_DIRECT  (TS_DIRECT),
        .PAT_INVERSE (TS_INVERSE)
    ) u_cls (
        .raw         (rx_raw),
        .hit_direct  (hit_dir),
        .hit_inverse (hit_inv)
    );

    // convention chosen for the current received character
    always_comb begin
        is_ts   = rx_valid && st_q.armed;
        ts_conv = st_q.det;
        if (is_ts && hit_inv)      ts_conv = CONV_INVERSE;
        else if (is_ts && hit_dir) ts_conv = CONV_DIRECT;
        inv_rx = force_en ? force_inv : (ts_conv == CONV_INVERSE);
        inv_tx = force_en ? force_inv : (st_q.det == CONV_INVERSE);
    end

    ts_bit_xform #(.W(DATA_W)) u_rx_xf (
        .din  (rx_raw),
        .pin  (rx_par),
        .inv  (inv_rx),
        .dout (rx_dec),
        .pout (rx_decp)
    );

    ts_bit_xform #(.W(DATA_W)) u_tx_xf (
        .din  (tx_data),
        .pin  (^tx_data),
        .inv  (inv_tx),
        .dout (tx_line),
        .pout (tx_linep)
    );

    assign mismatch = ^{rx_dec, rx_decp};

    always_comb begin
        st_d        = st_q;
        st_d.rx_vld = rx_valid;
        st_d.tx_vld = tx_valid;
        if (rx_valid) begin
            st_d.rx_dat  = conv_dis ? rx_raw : rx_dec;
            st_d.rx_perr = par_chk_en && mismatch;
            st_d.rx_brk  = brk_en && mismatch;
        end else begin
            st_d.rx_perr = 1'b0;
            st_d.rx_brk  = 1'b0;
        end
        if (is_ts) begin
            st_d.armed = 1'b0;
            st_d.det   = ts_conv;
            st_d.done  = hit_dir || hit_inv;
            st_d.err   = !(hit_dir || hit_inv);
        end
        if (ts_arm) begin
            st_d.armed = 1'b1;
            st_d.done  = 1'b0;
            st_d.err   = 1'b0;
        end
        if (tx_valid) begin
            st_d.tx_raw = conv_dis ? tx_data : tx_line;
            st_d.tx_par = tx_linep;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b0, det: CONV_DIRECT, done: 1'b0, err: 1'b0,
                      rx_vld: 1'b0, rx_dat: '0, rx_perr: 1'b0, rx_brk: 1'b0,
                      tx_vld: 1'b0, tx_raw: '0, tx_par: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_out_valid = st_q.rx_vld;
    assign rx_out_data  = st_q.rx_dat;
    assign rx_out_perr  = st_q.rx_perr;
    assign rx_break     = st_q.rx_brk;
    assign tx_out_valid = st_q.tx_vld;
    assign tx_out_raw   = st_q.tx_raw;
    assign tx_out_par   = st_q.tx_par;
    assign ts_inverse   = (st_q.det == CONV_INVERSE);
    assign ts_done      = st_q.done;
    assign ts_err       = st_q.err;

    p_rx_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_out_valid);
    p_rx_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !rx_out_valid);
    p_tx_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> tx_out_valid);
    p_done_err_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ts_done && ts_err));
    p_conv_needs_char_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(ts_inverse));
    p_break_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_en |=> !rx_break);
    p_perr_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !par_chk_en |=> !rx_out_perr);
endmodule

// File: tb/ts_conv_unit_tb.sv
module ts_conv_unit_tb;
    localparam int unsigned W = 8;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ts_arm = 0, force_en = 0, force_inv = 0, conv_dis = 0;
    logic par_chk_en = 1, brk_en = 1;
    logic rx_valid = 0, rx_par = 0, tx_valid = 0;
    logic [W-1:0] rx_raw = '0, tx_data = '0;
    logic rx_out_valid, rx_out_perr, rx_break, tx_out_valid, tx_out_par;
    logic ts_inverse, ts_done, ts_err;
    logic [W-1:0] rx_out_data, tx_out_raw;

    int n_chk = 0, n_fail = 0;
    logic [W+1:0] rx_q[$];   // {data, perr, brk}
    logic [W:0]   tx_q[$];   // {raw, par}
    logic         m_inv = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_conv_unit u_dut (.*);

    function automatic logic [W-1:0] ref_code(input logic [W-1:0] v, input logic inv);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = inv ? ~v[W-1-i] : v[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic eff_inv();
        return force_en ? force_inv : m_inv;
    endfunction

    task automatic send_rx(input logic [W-1:0] raw, input logic par, input logic armed);
        logic inv;
        logic [W-1:0] dec;
        logic mm;
        @(negedge clk);
        if (armed && raw == 8'h3B) m_inv = 1'b0;
        else if (armed && raw == 8'h03) m_inv = 1'b1;
        inv = eff_inv();
        dec = ref_code(raw, inv);
        mm  = ^dec ^ (inv ? ~par : par);
        rx_q.push_back({conv_dis ? raw : dec, par_chk_en & mm, brk_en & mm});
        rx_raw = raw; rx_par = par; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_tx(input logic [W-1:0] d);
        logic inv;
        @(negedge clk);
        inv = eff_inv();
        tx_q.push_back({conv_dis ? d : ref_code(d, inv), inv ? ~(^d) : ^d});
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk); ts_arm = 1'b1;
        @(negedge clk); ts_arm = 1'b0;
    endtask

    // scoreboard monitor (R12: output appears in the cycle after the input)
    always @(negedge clk) if (rst_n) begin
        if (rx_out_valid) begin
            if (rx_q.size() == 0) check("R12 rx unexpected", 1, 0);
            else begin
                logic [W+1:0] e;
                e = rx_q.pop_front();
                check("R6/R8/R9 rx data", rx_out_data, e[W+1:2]);
                check("R10 rx perr", rx_out_perr, e[1]);
                check("R11 rx break", rx_break, e[0]);
            end
        end
        if (tx_out_valid) begin
            if (tx_q.size() == 0) check("R12 tx unexpected", 1, 0);
            else begin
                logic [W:0] e;
                e = tx_q.pop_front();
                check("R7/R8 tx raw", tx_out_raw, e[W:1]);
                check("R7 tx parity", tx_out_par, e[0]);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rx_out_valid", rx_out_valid, 0);
        check("R1 tx_out_valid", tx_out_valid, 0);
        check("R1 flags", {rx_out_perr, rx_break, ts_done, ts_err, ts_inverse}, 0);

        // R2 direct TS
        arm();
        send_rx(8'h3B, 1'b1, 1'b1);
        check("R2 ts_done", ts_done, 1);
        check("R2 ts_inverse", ts_inverse, 0);
        // R5 later 0x03 does not reclassify
        send_rx(8'h03, 1'b0, 1'b0);
        check("R5 ts_inverse unchanged", ts_inverse, 0);
        send_tx(8'hA5);
        send_tx(8'h1C);

        // R3 inverse TS
        arm();
        check("R3 arm clears done", ts_done, 0);
        send_rx(8'h03, 1'b1, 1'b1);
        check("R3 ts_inverse", ts_inverse, 1);
        check("R3 ts_done", ts_done, 1);
        // R6 inverse data, good parity
        send_rx(8'h12, ~(^8'h12), 1'b0);
        send_rx(8'hC4, ~(^8'hC4), 1'b0);
        // R10/R11 parity error variants
        send_rx(8'h12, ^8'h12, 1'b0);
        par_chk_en = 0;
        send_rx(8'h37, ^8'h37, 1'b0);
        par_chk_en = 1; brk_en = 0;
        send_rx(8'h37, ^8'h37, 1'b0);
        brk_en = 1;
        send_rx(8'h3B, 1'b1, 1'b0);
        check("R5 ts_inverse unchanged", ts_inverse, 1);
        send_tx(8'hA5);
        send_tx(8'h1C);

        // R4 bad TS
        arm();
        send_rx(8'h55, 1'b0, 1'b1);
        check("R4 ts_err", ts_err, 1);
        check("R4 ts_done", ts_done, 0);
        check("R4 ts_inverse kept", ts_inverse, 1);

        // R9 force direct over detected inverse
        force_en = 1; force_inv = 0;
        send_rx(8'h61, ^8'h61, 1'b0);
        send_tx(8'h61);
        force_inv = 1;
        send_rx(8'h61, ~(^8'h61), 1'b0);
        force_en = 0;

        // R8 conversion disabled under inverse convention
        conv_dis = 1;
        send_rx(8'h1E, ~(^8'h1E), 1'b0);
        send_rx(8'h1E, ^8'h1E, 1'b0);
        send_tx(8'h1E);
        conv_dis = 0;

        // R12 valid deasserts after one cycle
        @(negedge clk);
        check("R12 rx idle", rx_out_valid, 0);
        check("R12 tx idle", tx_out_valid, 0);
        repeat (2) @(negedge clk);
        check("R12 queues drained", rx_q.size() + tx_q.size(), 0);
        finish_run();
    end
endmodule